// File: doc/BRIEF.md
# Receive Literal-Next Character Filter

This block sits in a serial receive path, after the character assembler and before the receive FIFO. Each character arrives on a valid/ready stream with a break flag and an error flag, which covers parity and framing errors. The block sends the character on toward the FIFO with one more flag, `out_bypass`. When that flag is set, downstream flow-control matching must treat the character as plain data.

While the filter is enabled, a character equal to a programmable escape value is marked as bypassed. It also arms a one-bit pending state, so the next character is bypassed as well. This lets software send flow-control bytes as ordinary data. If that next character carries a break or error flag, it is not bypassed and gets normal handling. The escape character itself has already gone out bypassed.

Both streams follow valid/ready rules. A transfer happens on a clock edge where valid and ready are both high. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output holds its data and flags steady.

Top module: `lnext_filter`

## Requirements
- R1: After reset, `out_valid` is 0, the escape value is 0x00, the filter is disabled and no escape is pending.
- R2: While disabled, every character comes out with `out_bypass` = 0 and with its data and flags unchanged.
- R3: A write with `cfg_addr` = 0 loads `cfg_wdata` as the escape value. A write with `cfg_addr` = 1 sets the enable bit from `cfg_wdata[0]`. Characters accepted from the next clock onward use the new setting.
- R4: While enabled and not pending, a character equal to the escape value with neither flag set comes out with `out_bypass` = 1 and arms the pending state.
- R5: While pending, a next character with no flags comes out with `out_bypass` = 1 and clears the pending state. This holds even if it equals the escape value, and in that case it does not arm a new escape.
- R6: While pending, a next character carrying break comes out with `out_bypass` = 0 and clears the pending state.
- R7: While pending, a next character carrying error comes out with `out_bypass` = 0 and clears the pending state.
- R8: Writing 0 to the enable bit clears any pending escape at that clock edge.
- R9: A character accepted at one clock edge is presented at the output after that edge, with its break and error flags unchanged. A non-matching character while not pending has `out_bypass` = 0.
- R10: `in_ready` = `!out_valid || out_ready`. While `out_valid` = 1 and `out_ready` = 0, the output data and flags stay stable.
- R11: An escape-valued character that itself carries break or error is not treated as an escape: `out_bypass` = 0 and nothing is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Filter can accept a character |
| in_data | input | DATA_W | Received character |
| in_brk | input | 1 | Character is a break |
| in_err | input | 1 | Character has a parity or framing error |
| out_valid | output | 1 | Output character valid |
| out_ready | input | 1 | FIFO side can accept |
| out_data | output | DATA_W | Character toward the FIFO |
| out_brk | output | 1 | Break flag, passed through |
| out_err | output | 1 | Error flag, passed through |
| out_bypass | output | 1 | Skip special-character processing |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = escape value, 1 = control (bit 0 enable) |
| cfg_wdata | input | DATA_W | Register write data |

## Verification
The bench builds the block with the default DATA_W of 8, so escape values such as 0x00 and 0x1B and flow-control codes can be driven directly. At that width, random data drawn from a small set often hits the escape value back to back. This drives the cases of chained escapes, escape-valued followers and flagged followers. Randomized `out_ready` stalls exercise back-pressure while escapes are pending.

// File: rtl/lnext_pkg.sv
package lnext_pkg;
  localparam logic ADDR_ESCAPE  = 1'b0;
  localparam logic ADDR_CONTROL = 1'b1;

  typedef struct packed {
    logic bypass;
    logic brk;
    logic err;
  } char_tag_t;

  localparam int TAG_W = $bits(char_tag_t);
endpackage

// File: rtl/lnext_cfg_regs.sv
module lnext_cfg_regs
  import lnext_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] esc_value,
  output logic              enable,
  output logic              disable_wr
);
  assign disable_wr = cfg_wr && (cfg_addr == ADDR_CONTROL) && !cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esc_value <= '0;
      enable    <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_addr == ADDR_ESCAPE) esc_value <= cfg_wdata;
      else                         enable    <= cfg_wdata[0];
    end
  end
endmodule

// File: rtl/lnext_escape_tracker.sv
module lnext_escape_tracker #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              enable,
  input  logic              clear,
  input  logic [DATA_W-1:0] esc_value,
  input  logic [DATA_W-1:0] data,
  input  logic              brk,
  input  logic              err,
  output logic              bypass
);
  logic pending_q;
  logic flagged;
  logic starts_escape;

  always_comb begin
    flagged       = brk || err;
    starts_escape = enable && !pending_q && !flagged && (data == esc_value);
    if (!enable)        bypass = 1'b0;
    else if (pending_q) bypass = !flagged;
    else                bypass = starts_escape;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pending_q <= 1'b0;
    else if (clear)  pending_q <= 1'b0;
    else if (accept) pending_q <= starts_escape;
  end

  AST_FOLLOWER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && pending_q |=> !pending_q); // R5
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending_q); // R8
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pending_q); // R2
  AST_FLAGGED_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !pending_q && (brk || err) && !clear |=> !pending_q); // R11
endmodule

// File: rtl/lnext_out_stage.sv
module lnext_out_stage #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_payload <= in_payload;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_payload)); // R10
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
endmodule

// File: rtl/lnext_filter.sv
module lnext_filter
  import lnext_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_brk,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_brk,
  output logic              out_err,
  output logic              out_bypass,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata
);
  localparam int PAY_W = DATA_W + TAG_W;

  logic [DATA_W-1:0] esc_value;
  logic              enable;
  logic              disable_wr;
  logic              bypass;
  logic              accept;
  char_tag_t         tag_in;
  char_tag_t         tag_out;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  assign accept = in_valid && in_ready;

  lnext_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .esc_value(esc_value), .enable(enable),
    .disable_wr(disable_wr)
  );

  lnext_escape_tracker #(.DATA_W(DATA_W)) u_track (
    .clk(clk), .rst_n(rst_n), .accept(accept), .enable(enable),
    .clear(disable_wr), .esc_value(esc_value), .data(in_data),
    .brk(in_brk), .err(in_err), .bypass(bypass)
  );

  always_comb begin
    tag_in.bypass = bypass;
    tag_in.brk    = in_brk;
    tag_in.err    = in_err;
    pay_in        = {tag_in, in_data};
  end

  lnext_out_stage #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_payload(pay_in), .out_valid(out_valid), .out_ready(out_ready),
    .out_payload(pay_out)
  );

  assign tag_out    = char_tag_t'(pay_out[PAY_W-1:DATA_W]);
  assign out_data   = pay_out[DATA_W-1:0];
  assign out_brk    = tag_out.brk;
  assign out_err    = tag_out.err;
  assign out_bypass = tag_out.bypass;

  AST_FLAGGED_NOT_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_brk || out_err) |-> !out_bypass); // R6
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
endmodule

// File: tb/lnext_filter_test.sv
module lnext_filter_test;
  localparam int DATA_W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_brk = 0, in_err = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_brk, out_err, out_bypass;
  logic out_ready = 1;
  logic [DATA_W-1:0] out_data;
  logic cfg_wr = 0, cfg_addr = 0;
  logic [DATA_W-1:0] cfg_wdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  bit rand_ready = 0;
  bit done = 0;
  string force_tag = "";

  always #2 clk = ~clk;

  lnext_filter #(.DATA_W(DATA_W)) uut (.*);

  // reference model state
  bit m_en = 0, m_pend = 0;
  logic [DATA_W-1:0] m_esc = '0;
  logic [DATA_W+2:0] q_item[$];
  string q_tag[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pend = 0; m_esc = '0;
      q_item.delete(); q_tag.delete();
    end else begin
      if (out_valid && out_ready && q_item.size() > 0) begin
        void'(q_item.pop_front()); void'(q_tag.pop_front());
      end
      if (in_valid && (!out_valid || out_ready)) begin
        bit byp; string t;
        if (!m_en) begin byp = 0; t = "R2"; end
        else if (m_pend) begin
          m_pend = 0;
          if (in_brk) begin byp = 0; t = "R6"; end
          else if (in_err) begin byp = 0; t = "R7"; end
          else begin byp = 1; t = "R5"; end
        end else if (in_data == m_esc && !in_brk && !in_err) begin
          byp = 1; m_pend = 1; t = "R4";
        end else if (in_data == m_esc) begin byp = 0; t = "R11"; end
        else begin byp = 0; t = "R9"; end
        if (force_tag != "") t = force_tag;
        q_item.push_back({byp, in_brk, in_err, in_data});
        q_tag.push_back(t);
      end
      if (cfg_wr) begin
        if (cfg_addr) begin m_en = cfg_wdata[0]; if (!cfg_wdata[0]) m_pend = 0; end
        else m_esc = cfg_wdata;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        errors++;
        $display("FAIL R10: in_ready got %b expected %b", in_ready, !out_valid || out_ready);
      end
      checks++;
      if (out_valid !== (q_item.size() > 0)) begin
        errors++;
        $display("FAIL R9: out_valid got %b expected %b", out_valid, q_item.size() > 0);
      end else if (out_valid) begin
        checks++;
        if ({out_bypass, out_brk, out_err, out_data} !== q_item[0]) begin
          errors++;
          $display("FAIL %s: got byp=%b brk=%b err=%b data=%h expected %h",
                   q_tag[0], out_bypass, out_brk, out_err, out_data, q_item[0]);
        end
      end
    end
    if (rand_ready) out_ready = $urandom_range(0, 2) != 0;
  end

  task automatic send(input logic [DATA_W-1:0] d, input logic b, input logic e);
    @(negedge clk);
    in_valid = 1; in_data = d; in_brk = b; in_err = e;
    forever begin
      @(posedge clk);
      if (in_ready) break;
    end
    @(negedge clk);
    in_valid = 0; in_brk = 0; in_err = 0;
  endtask

  task automatic cfg(input logic a, input logic [DATA_W-1:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic drain();
    rand_ready = 0;
    @(negedge clk);
    out_ready = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid !== 0) begin
      errors++;
      $display("FAIL R1: out_valid got %b expected 0", out_valid);
    end
    // R1: default escape 0x00 is live once enabled
    force_tag = "R1";
    cfg(1, 8'h01);
    send(8'h00, 0, 0);
    send(8'h41, 0, 0);
    force_tag = "";
    // R2: disabled passes everything unmarked
    cfg(1, 8'h00);
    send(8'h11, 0, 0);
    send(8'h13, 0, 0);
    send(8'h00, 0, 0);
    // R3: new escape value and enable
    cfg(0, 8'h1B);
    cfg(1, 8'h01);
    force_tag = "R3";
    send(8'h1B, 0, 0);
    force_tag = "";
    send(8'h13, 0, 0);
    send(8'h00, 0, 0);   // old escape no longer matches
    send(8'h1B, 0, 0);
    send(8'h1B, 0, 0);   // R5 literal escape-valued follower
    send(8'h1B, 0, 0);   // new escape
    send(8'h11, 0, 0);
    send(8'h1B, 0, 1);   // R11 flagged escape
    send(8'h13, 0, 0);
    send(8'h1B, 1, 0);   // R11 break escape
    send(8'h1B, 0, 0);
    send(8'h00, 1, 0);   // R6
    send(8'h1B, 0, 0);
    send(8'h55, 0, 1);   // R7
    send(8'h13, 0, 0);
    // R8: disable clears pending
    send(8'h1B, 0, 0);
    cfg(1, 8'h00);
    cfg(1, 8'h01);
    force_tag = "R8";
    send(8'h13, 0, 0);
    force_tag = "";
    drain();
    // R10: random back-pressure with frequent escapes
    rand_ready = 1;
    for (int i = 0; i < 400; i++) begin
      logic [DATA_W-1:0] d;
      int k = $urandom_range(0, 3);
      d = (k == 0) ? 8'h13 : (k == 1) ? 8'h11 : (k == 2) ? 8'h1B : 8'($urandom);
      if ($urandom_range(0, 3) == 0) d = 8'h1B;
      if (i == 200) cfg(1, 8'h00);
      if (i == 210) cfg(1, 8'h01);
      send(d, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end
    drain();
    finish_run();
  end
endmodule